// File: doc/BRIEF.md
# Powered-Device Sleep Controller and Signature Pulser

This block runs the low-power side of a powered device on a power-over-ethernet link. Three active-low request pins arrive asynchronously: a sleep request, a wake request and an ultra-low-power select. The block resynchronises them and reacts to their falling edges. A falling sleep edge puts an active device into one of two sleep modes; a falling wake edge brings it back. The choice between the two sleep modes is the level of the ultra-low-power pin at the moment the sleep edge is seen.

While asleep, the block asks the power stage to hold power-good low and to switch the type-indicator sink off. The isolation switch is untouched. It also produces two timing signals. The first is a 25 % duty enable for the LED current source. The second is an enable for the internal current that keeps the link's maintain-power-signature alive: a 75 % duty pulse in normal sleep, and a long on/off cycle in ultra-low-power sleep. All periods are derived from a clock-frequency parameter, so the same code can run at silicon rate or with short periods in simulation.

Top module: `pd_sleep_ctrl`

## Requirements
- R1: After reset every output is low and the block is awake.
- R2: A falling edge on `sleep_ni` while `power_on_i` is high enters sleep. The first cycle with `pg_force_low_o` and `ind_sink_off_o` high is the third rising clock edge after the pin falls. Rising edges of any request pin have no effect.
- R3: A falling edge on `sleep_ni` while `power_on_i` is low is ignored. Raising `power_on_i` later with the pin still low does not start sleep.
- R4: If `ulp_ni` is low when the sleep falling edge is detected, the block enters ultra-low-power sleep; otherwise it enters normal sleep.
- R5: A falling edge on `wake_ni` leaves either sleep mode, with the same three-edge latency; all outputs then return low.
- R6: In both sleep modes `led_en_o` repeats with period CLK_HZ/250 cycles (LED_FAST=0) or CLK_HZ/15625 cycles (LED_FAST=1). It is high for the first quarter of each period, starting in the first sleep cycle.
- R7: In normal sleep `mps_en_o` is high for the first three quarters of each LED period.
- R8: In ultra-low-power sleep `mps_en_o` is high for CLK_HZ*84/1000 cycles and then low for CLK_HZ*228/1000 cycles, repeating and starting with the high phase.
- R9: While `therm_fault_i` is high, `led_en_o` is low in the same cycle. The LED phase keeps counting, so the pattern resumes in step when the fault clears.
- R10: If `power_on_i` falls while asleep, the block is awake from the next clock edge.
- R11: Leaving sleep clears all pulse counters, so every sleep entry begins with the on-phase of each pattern.
- R12: `led_en_o` and `mps_en_o` are high only while `pg_force_low_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_ni | input | 1 | Sleep request pin, asynchronous, falling edge acts |
| wake_ni | input | 1 | Wake request pin, asynchronous, falling edge acts |
| ulp_ni | input | 1 | Ultra-low-power select pin, asynchronous, low selects |
| power_on_i | input | 1 | Device is in power mode |
| therm_fault_i | input | 1 | Thermal fault flag |
| led_en_o | output | 1 | LED current source enable |
| mps_en_o | output | 1 | Internal signature current enable |
| pg_force_low_o | output | 1 | Request to hold power-good low |
| ind_sink_off_o | output | 1 | Request to switch the indicator sink off |

## Verification
The checker watches four things on every cycle. Thermal faults must mask the LED at once, and a loss of power mode must end sleep on the next edge. Neither pulse enable may be active outside sleep, and each sleep entry must begin with the signature current on. The exact pulse shapes cannot be seen by those properties and are left to the bench scenarios. These cover the quarter and three-quarter duty in both LED rate variants, the 84/228 ms cycle in ultra-low-power sleep, the three-edge entry latency and the restart of the phase after a wake. The bench scenarios also cover edges that must be ignored.

// File: rtl/pd_sleep_pkg.sv
package pd_sleep_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_SLEEP = 2'd1,
    ST_ULP   = 2'd2
  } slp_state_e;
endpackage

// File: rtl/pd_pin_sync.sv
module pd_pin_sync #(
  parameter int N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o
);
  // pins idle high, so reset to 1 to avoid a false edge
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= pin_i[g];
        s2 <= s1;
      end
    end
    assign lvl_o[g] = s2;
  end
endmodule

// File: rtl/pd_fall_det.sv
module pd_fall_det #(
  parameter int N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end
  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/pd_pulse_gen.sv
module pd_pulse_gen #(
  parameter int PERIOD = 4,
  parameter int ON_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic on_o
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] ONL  = CW'(ON_CYC);

  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;   // phase restarts on every entry
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
  assign on_o = en_i && (cnt_q < ONL);
endmodule

// File: rtl/pd_sleep_fsm.sv
module pd_sleep_fsm
  import pd_sleep_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_fall_i,
  input  logic       wake_fall_i,
  input  logic       ulp_lvl_i,
  input  logic       power_on_i,
  output slp_state_e state_o
);
  slp_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_AWAKE: if (power_on_i && sleep_fall_i) st_d = ulp_lvl_i ? ST_SLEEP : ST_ULP;
      ST_SLEEP,
      ST_ULP:   if (!power_on_i || wake_fall_i) st_d = ST_AWAKE;
      default:  st_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_AWAKE;
    else         st_q <= st_d;
  end
  assign state_o = st_q;
endmodule

// File: rtl/pd_sleep_ctrl.sv
module pd_sleep_ctrl
  import pd_sleep_pkg::*;
#(
  parameter int CLK_HZ     = 25_000_000,
  parameter bit LED_FAST   = 1'b0,
  parameter int ULP_ON_MS  = 84,
  parameter int ULP_OFF_MS = 228
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_ni,
  input  logic wake_ni,
  input  logic ulp_ni,
  input  logic power_on_i,
  input  logic therm_fault_i,
  output logic led_en_o,
  output logic mps_en_o,
  output logic pg_force_low_o,
  output logic ind_sink_off_o
);
  localparam int LED_HZ     = LED_FAST ? 15625 : 250;
  localparam int LED_PERIOD = CLK_HZ / LED_HZ;
  localparam int LED_ON     = LED_PERIOD / 4;
  localparam int SIG_ON     = (LED_PERIOD * 3) / 4;
  localparam int ULP_ON     = (CLK_HZ / 1000) * ULP_ON_MS;
  localparam int ULP_PERIOD = ULP_ON + (CLK_HZ / 1000) * ULP_OFF_MS;

  logic [2:0] lvl;
  logic [1:0] fall;
  slp_state_e st;
  logic asleep, led_on, nsig_on, usig_on;

  pd_pin_sync #(.N(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i ({ulp_ni, wake_ni, sleep_ni}),
    .lvl_o (lvl)
  );

  pd_fall_det #(.N(2)) u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl[1:0]),
    .fall_o(fall)
  );

  pd_sleep_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_fall_i(fall[0]),
    .wake_fall_i (fall[1]),
    .ulp_lvl_i   (lvl[2]),
    .power_on_i  (power_on_i),
    .state_o     (st)
  );

  assign asleep = (st != ST_AWAKE);

  pd_pulse_gen #(.PERIOD(LED_PERIOD), .ON_CYC(LED_ON)) u_led (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(asleep), .on_o(led_on)
  );

  pd_pulse_gen #(.PERIOD(LED_PERIOD), .ON_CYC(SIG_ON)) u_nsig (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(st == ST_SLEEP), .on_o(nsig_on)
  );

  pd_pulse_gen #(.PERIOD(ULP_PERIOD), .ON_CYC(ULP_ON)) u_usig (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(st == ST_ULP), .on_o(usig_on)
  );

  // fault masks the LED only; phase counter keeps running
  assign led_en_o       = led_on && !therm_fault_i;
  assign mps_en_o       = nsig_on || usig_on;
  assign pg_force_low_o = asleep;
  assign ind_sink_off_o = asleep;
endmodule

// File: rtl/pd_sleep_ctrl_chk.sv
module pd_sleep_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic power_on_i,
  input logic therm_fault_i,
  input logic led_en_o,
  input logic mps_en_o,
  input logic pg_force_low_o,
  input logic ind_sink_off_o
);
  assert_therm_led_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_fault_i |-> !led_en_o);

  assert_power_loss_wakes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !power_on_i |=> (!pg_force_low_o && !ind_sink_off_o));

  assert_led_only_asleep_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_en_o |-> pg_force_low_o);

  assert_mps_only_asleep_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mps_en_o |-> pg_force_low_o);

  assert_entry_on_phase_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_force_low_o) |-> mps_en_o);
endmodule

bind pd_sleep_ctrl pd_sleep_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .power_on_i    (power_on_i),
  .therm_fault_i (therm_fault_i),
  .led_en_o      (led_en_o),
  .mps_en_o      (mps_en_o),
  .pg_force_low_o(pg_force_low_o),
  .ind_sink_off_o(ind_sink_off_o)
);

// File: tb/sim_pd_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_pd_sleep_ctrl;
  localparam int CLK_HZ = 64000;
  // expected geometry from the requirements at CLK_HZ=64000
  localparam int P_SLOW = 256;    // R6: 64000/250
  localparam int P_FAST = 4;      // R6: 64000/15625
  localparam int U_ON   = 5376;   // R8: 64*84
  localparam int U_PER  = 19968;  // R8: 64*(84+228)

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_n = 1'b1, wake_n = 1'b1, ulp_n = 1'b1, power = 1'b0, therm = 1'b0;
  logic led0, mps0, pg0, sink0, led1, mps1, pg1, sink1;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [7:0] req;
    logic led0, mps0, slp, led1;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  pd_sleep_ctrl #(.CLK_HZ(CLK_HZ), .LED_FAST(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sleep_ni(sleep_n), .wake_ni(wake_n), .ulp_ni(ulp_n),
    .power_on_i(power), .therm_fault_i(therm), .led_en_o(led0), .mps_en_o(mps0),
    .pg_force_low_o(pg0), .ind_sink_off_o(sink0));

  pd_sleep_ctrl #(.CLK_HZ(CLK_HZ), .LED_FAST(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .sleep_ni(sleep_n), .wake_ni(wake_n), .ulp_ni(ulp_n),
    .power_on_i(power), .therm_fault_i(therm), .led_en_o(led1), .mps_en_o(mps1),
    .pg_force_low_o(pg1), .ind_sink_off_o(sink1));

  // mode: 0 awake, 1 normal sleep, 2 ultra-low-power sleep; k = cycles since entry
  function automatic item_t mk(int req, int mode, int k, logic th);
    item_t it;
    it.req  = 8'(req);
    it.slp  = (mode != 0);
    it.led0 = (mode != 0) && !th && ((k % P_SLOW) < P_SLOW / 4);
    it.led1 = (mode != 0) && !th && ((k % P_FAST) < P_FAST / 4);
    it.mps0 = (mode == 1) ? ((k % P_SLOW) < (3 * P_SLOW) / 4) :
              (mode == 2) ? ((k % U_PER) < U_ON) : 1'b0;
    return it;
  endfunction

  task automatic run(int req, int mode, int k0, int n, logic th);
    for (int i = 0; i < n; i++) begin
      q.push_back(mk(req, mode, k0 + i, th));
      @(negedge clk);
    end
  endtask

  // monitor: pops one expectation per cycle, sampled just after the falling edge
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (led0 !== it.led0 || mps0 !== it.mps0 || pg0 !== it.slp || sink0 !== it.slp ||
          pg1 !== it.slp || led1 !== it.led1) begin
        errors++;
        $display("FAIL R%0d t=%0t: got led=%b mps=%b pg=%b sink=%b led_fast=%b, expected led=%b mps=%b pg=%b sink=%b led_fast=%b",
                 it.req, $time, led0, mps0, pg0, sink0, led1,
                 it.led0, it.mps0, it.slp, it.slp, it.led1);
      end
    end
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(1, 0, 0, 4, 0);                       // R1 reset state

    sleep_n = 1'b0; run(3, 0, 0, 8, 0);       // R3 edge without power mode
    power = 1'b1;   run(3, 0, 0, 6, 0);       // R3 stale low pin does nothing
    sleep_n = 1'b1; run(3, 0, 0, 4, 0);

    sleep_n = 1'b0; run(2, 0, 0, 3, 0);       // R2 three-edge latency
    run(7, 1, 0, 600, 0);                      // R6 R7 normal sleep patterns
    sleep_n = 1'b1; run(2, 1, 600, 8, 0);     // R2 rising edge ignored

    therm = 1'b1; run(9, 1, 608, 300, 1);     // R9 LED masked
    therm = 1'b0; run(9, 1, 908, 100, 0);     // R9 resumes in step

    wake_n = 1'b0; run(5, 1, 1008, 3, 0);     // R5 wake latency
    run(5, 0, 0, 5, 0);
    wake_n = 1'b1; run(5, 0, 0, 3, 0);

    sleep_n = 1'b0; run(11, 0, 0, 3, 0);      // R11 entry, wake mid-period, re-entry
    run(11, 1, 0, 100, 0);
    sleep_n = 1'b1; wake_n = 1'b0; run(11, 1, 100, 3, 0);
    run(11, 0, 0, 3, 0);
    wake_n = 1'b1; sleep_n = 1'b0; run(11, 0, 0, 3, 0);
    run(11, 1, 0, 70, 0);
    sleep_n = 1'b1; wake_n = 1'b0; run(5, 1, 70, 3, 0);
    run(5, 0, 0, 3, 0);
    wake_n = 1'b1;

    ulp_n = 1'b0; run(4, 0, 0, 3, 0);         // R4 select ultra-low-power
    sleep_n = 1'b0; run(4, 0, 0, 3, 0);
    run(8, 2, 0, 45000, 0);                    // R8 two full on/off cycles
    ulp_n = 1'b1; sleep_n = 1'b1; run(8, 2, 45000, 10, 0);

    power = 1'b0; run(10, 2, 45010, 1, 0);    // R10 power loss exits next edge
    run(10, 0, 0, 5, 0);
    power = 1'b1; run(10, 0, 0, 3, 0);

    ulp_n = 1'b0; run(4, 0, 0, 3, 0);         // R5 wake from ultra-low-power sleep
    sleep_n = 1'b0; run(4, 0, 0, 3, 0);
    run(4, 2, 0, 50, 0);
    wake_n = 1'b0; run(5, 2, 50, 3, 0);
    run(5, 0, 0, 4, 0);
    wake_n = 1'b1; sleep_n = 1'b1; ulp_n = 1'b1;
    run(12, 0, 0, 4, 0);                       // R12 awake, no pulses

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule